// File: doc/BRIEF.md
# Four-Pin Bidirectional Port with Direction Control

This block is the I/O port of a small 8-bit processor core. It holds a 4-bit output latch and a 4-bit direction register, and it drives per-pin output-value and output-enable signals to the pads. The core issues one operation per instruction cycle through a one-hot select. The operations are: load the latch, load the direction, read the port, and set or clear a single bit. A strobe marks the last clock of each instruction cycle, and every latch and direction change takes effect on that clock.

A port read returns the pin levels, not the latch. The pins pass through a two-flop synchroniser and are then captured at each instruction boundary, so a read sees the pins as they stood when its instruction began. Bit set and bit clear work on that same captured pin image. They change one bit and write all four bits back into the latch. On a pin that is configured as an input, this copies the level seen on the pin into the latch bit. Power-on reset clears the latch. The model picks zero because the real value at that point is undefined. The separate system reset only returns every pin to input mode.

Top module: `quad_io_port`

## Requirements
- R1: After power-on reset (`rst_n` low) every pin is an input (`padOe` = 0000), the latch is 0000 (`padOut` = 0000), and a read in the first instruction returns 0x00.
- R2: A one-clock pulse on `sysRst` returns all direction bits to input (`padOe` = 0000) and leaves the latch unchanged.
- R3: `padOut` shows the latch. `padOe[i]` is 1 exactly when direction bit i is 0, meaning the pin is an output.
- R4: Write (`opSel` = 5'b00001) loads `wrData[3:0]` into the latch. Bits 7:4 are ignored.
- R5: Direction load (`opSel` = 5'b01000) loads `wrData[3:0]` into the direction register. A 1 means input and bits 7:4 are ignored. The register cannot be read back.
- R6: During a read (`opSel` = 5'b10000), `rdData` is {0000, captured pins}. The captured pins are the synchronised pin levels taken on the last clock of the previous instruction. Output pins are included. At all other times `rdData` is 0x00.
- R7: A read in the instruction right after a latch write returns the pin levels from before that write.
- R8: Bit set (`opSel` = 5'b00010) and bit clear (`opSel` = 5'b00100) load the latch with the captured pin image, with bit `bitIdx` forced to 1 or 0 respectively. Input pins therefore have their latch bits overwritten with their pin levels.
- R9: An `opSel` value that is not one-hot (zero, or more than one bit set) changes neither the latch nor the direction.
- R10: The latch and direction change only on a clock where `cycEnd` is 1. An operation held with `cycEnd` low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| sysRst | input | 1 | System reset, synchronous, active high; resets direction only |
| cycEnd | input | 1 | High on the last clock of an instruction cycle |
| opSel | input | 5 | One-hot operation: bit0 write, bit1 set, bit2 clear, bit3 direction, bit4 read |
| bitIdx | input | 2 | Bit addressed by set or clear |
| wrData | input | 8 | Data for write and direction load |
| pinIn | input | 4 | Pin levels from the pads |
| rdData | output | 8 | Port read data |
| padOut | output | 4 | Output value per pin |
| padOe | output | 4 | Output enable per pin, high means the pin drives |

## Verification
The hardest case to reach is latch corruption by a bit operation. It needs three things at once: an input pin whose external level differs from its latch bit, a set or clear on a different bit, and a later switch of that pin to output, which exposes the copied level. The stimulus sets this up in order. It makes bit 0 an input with latch 0 and drives it high from outside. It lets an instruction pass so the synchroniser and the boundary capture settle. It then sets bit 2 and turns every pin into an output, where `padOut[0]` shows the corrupted 1. The stale read after a write is reached the same way, by issuing a read in the instruction right after a write to output pins.

// File: rtl/qio_pkg.sv
package qio_pkg;
  localparam int OP_W     = 5;
  localparam int OP_WRITE = 0;
  localparam int OP_SET   = 1;
  localparam int OP_CLR   = 2;
  localparam int OP_DIR   = 3;
  localparam int OP_READ  = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic latchLd;  // load latch from bus
    logic bitMod;   // load latch from modified pin image
    logic bitVal;   // value forced into the addressed bit
    logic dirLd;    // load direction from bus
    logic dirRst;   // force all pins to input
    logic sampLd;   // capture synchronised pins at the boundary
    logic rdEn;     // present captured pins on the read bus
  } qioCtl_t;
endpackage

// File: rtl/qio_ctrl.sv
module qio_ctrl
  import qio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opSel,
  input  logic            cycEnd,
  input  logic            sysRst,
  output qioCtl_t         ctl
);
  logic opValid;
  assign opValid = $onehot(opSel);

  always_comb begin
    ctl.latchLd = cycEnd & opValid & opSel[OP_WRITE];
    ctl.bitMod  = cycEnd & opValid & (opSel[OP_SET] | opSel[OP_CLR]);
    ctl.bitVal  = opSel[OP_SET];
    ctl.dirRst  = sysRst;
    ctl.dirLd   = cycEnd & opValid & opSel[OP_DIR] & ~sysRst;
    ctl.sampLd  = cycEnd;
    ctl.rdEn    = opValid & opSel[OP_READ];
  end

  // at most one committing strobe per clock (R9)
  assert_commit_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.latchLd, ctl.bitMod, ctl.dirLd}));
  // nothing commits off the boundary clock (R10)
  assert_commit_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cycEnd |-> !(ctl.latchLd | ctl.bitMod | ctl.dirLd));
endmodule

// File: rtl/qio_dp.sv
module qio_dp
  import qio_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qioCtl_t          ctl,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic [WIDTH-1:0] wrBits,
  input  logic [WIDTH-1:0] pinIn,
  output logic [BUS_W-1:0] rdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe
);
  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncQ;
  logic [WIDTH-1:0] sampQ, latchQ, dirQ, modPins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sampQ <= '0;
    else if (ctl.sampLd) sampQ <= syncQ[SYNC_STAGES-1];
  end

  // read-modify-write image: captured pins with one bit forced
  for (genvar b = 0; b < WIDTH; b++) begin : g_mod
    assign modPins[b] = (bitIdx == IDX_W'(b)) ? ctl.bitVal : sampQ[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           latchQ <= '0;
    else if (ctl.latchLd) latchQ <= wrBits;
    else if (ctl.bitMod)  latchQ <= modPins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dirQ <= '1;
    else if (ctl.dirRst) dirQ <= '1;
    else if (ctl.dirLd)  dirQ <= wrBits;
  end

  assign padOut = latchQ;
  assign padOe  = ~dirQ;
  assign rdData = ctl.rdEn ? BUS_W'(sampQ) : '0;

  // captured image changes only at a boundary (R6)
  assert_samp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.sampLd |=> $stable(sampQ));
  // direction reset wins over load (R2)
  assert_dir_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.dirRst |=> dirQ == '1);
endmodule

// File: rtl/quad_io_port.sv
module quad_io_port
  import qio_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sysRst,
  input  logic             cycEnd,
  input  logic [OP_W-1:0]  opSel,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic [BUS_W-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [BUS_W-1:0] rdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe
);
  qioCtl_t ctl;
  logic unusedHiBits;
  assign unusedHiBits = ^wrData[BUS_W-1:WIDTH];

  qio_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opSel(opSel), .cycEnd(cycEnd),
    .sysRst(sysRst), .ctl(ctl)
  );

  qio_dp #(.WIDTH(WIDTH), .BUS_W(BUS_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .bitIdx(bitIdx),
    .wrBits(wrData[WIDTH-1:0]), .pinIn(pinIn), .rdData(rdData),
    .padOut(padOut), .padOe(padOe)
  );

  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cycEnd |=> $stable(padOut));
  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycEnd && !sysRst) |=> $stable(padOe));
  assert_sysrst_inputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sysRst |=> padOe == '0);
  assert_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cycEnd && opSel == OP_W'(1 << OP_WRITE)) |=> padOut == $past(wrData[WIDTH-1:0]));
  assert_bitset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycEnd && opSel == OP_W'(1 << OP_SET)) |=> padOut[$past(bitIdx)]);
  assert_bitclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycEnd && opSel == OP_W'(1 << OP_CLR)) |=> !padOut[$past(bitIdx)]);
  assert_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cycEnd && !sysRst && !$onehot(opSel)) |=> ($stable(padOut) && $stable(padOe)));
  assert_rd_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    opSel != OP_W'(1 << OP_READ) |-> rdData == '0);
endmodule

// File: tb/tb_quad_io_port.sv
`timescale 1ns/1ps
module tb_quad_io_port;
  localparam logic [4:0] OPW = 5'b00001, OPS = 5'b00010, OPC = 5'b00100,
                         OPD = 5'b01000, OPR = 5'b10000;
  logic clk = 0, rst_n = 0, sysRst = 0, cycEnd = 0;
  logic [4:0] opSel = '0;
  logic [1:0] bitIdx = '0;
  logic [7:0] wrData = '0, rdData;
  logic [3:0] pinIn, padOut, padOe, extDrv = 4'b1010;
  logic [3:0] mLatch = '0, mDir = '1, mSamp = '0;
  logic [7:0] expQ[$];
  string tagQ[$];
  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign pinIn = (padOe & padOut) | (~padOe & extDrv);

  quad_io_port dut (.clk(clk), .rst_n(rst_n), .sysRst(sysRst), .cycEnd(cycEnd),
    .opSel(opSel), .bitIdx(bitIdx), .wrData(wrData), .pinIn(pinIn),
    .rdData(rdData), .padOut(padOut), .padOe(padOe));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compares reads against queued expectations
  always begin
    @(negedge clk); #1;
    if (cycEnd && opSel == OPR) begin
      if (expQ.size() == 0) check("R6 unexpected read", rdData, 8'hxx);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  // driver: one instruction of four clocks, called just after a negedge
  task automatic doInstr(input logic [4:0] op, input logic [1:0] idx,
                         input logic [7:0] d, input string tag);
    logic [3:0] cur;
    opSel = op; bitIdx = idx; wrData = d; cycEnd = 0;
    if (op == OPR) begin expQ.push_back({4'h0, mSamp}); tagQ.push_back(tag); end
    repeat (3) @(negedge clk);
    cycEnd = 1;
    @(negedge clk);
    cycEnd = 0; opSel = '0;
    cur = (mDir & extDrv) | (~mDir & mLatch);
    case (op)
      OPW: mLatch = d[3:0];
      OPD: mDir = d[3:0];
      OPS: begin mLatch = mSamp; mLatch[idx] = 1'b1; end
      OPC: begin mLatch = mSamp; mLatch[idx] = 1'b0; end
      default: ;
    endcase
    mSamp = cur;
  endtask

  task automatic checkPads(input string tag);
    check({tag, " padOut"}, {4'h0, padOut}, {4'h0, mLatch});
    check({tag, " padOe"}, {4'h0, padOe}, {4'h0, ~mDir});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog all-R act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkPads("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    checkPads("R1 after reset");
    doInstr(OPR, 0, 0, "R1 first read");
    doInstr(OPR, 0, 0, "R6 input pins");
    doInstr(OPW, 0, 8'hF5, "");
    checkPads("R4 write upper ignored");
    doInstr(OPD, 0, 8'hF0, "");
    checkPads("R5 R3 all outputs");
    doInstr(OPR, 0, 0, "R6 pins before dir load");
    doInstr(OPR, 0, 0, "R6 output pins read");
    doInstr(OPW, 0, 8'h0A, "");
    doInstr(OPR, 0, 0, "R7 stale read after write");
    doInstr(OPR, 0, 0, "R6 read after settle");
    // read-modify-write corruption setup
    doInstr(OPD, 0, 8'h01, "");
    doInstr(OPW, 0, 8'h00, "");
    extDrv = 4'b1111;
    doInstr(OPR, 0, 0, "R6 settle input");
    doInstr(OPR, 0, 0, "R6 input bit0 high");
    doInstr(OPS, 2, 0, "");
    checkPads("R8 bitset copies input pin");
    check("R8 corrupted latch", {4'h0, padOut}, 8'h05);
    doInstr(OPD, 0, 8'h00, "");
    checkPads("R8 R3 corruption exposed");
    doInstr(OPC, 0, 0, "");
    checkPads("R8 bitclr");
    check("R8 bitclr value", {4'h0, padOut}, 8'h04);
    doInstr(5'b00011, 1, 8'hFF, "");
    checkPads("R9 two-hot ignored");
    doInstr(5'b00000, 3, 8'hFF, "");
    checkPads("R9 zero select ignored");
    // R10: write held without boundary strobe
    opSel = OPW; wrData = 8'h0F;
    repeat (4) @(negedge clk);
    opSel = '0;
    checkPads("R10 no commit without cycEnd");
    sysRst = 1;
    @(negedge clk);
    sysRst = 0; mDir = '1;
    checkPads("R2 system reset");
    extDrv = 4'b0110;
    doInstr(OPR, 0, 0, "R6 after sysRst");
    doInstr(OPR, 0, 0, "R2 R6 inputs after sysRst");
    repeat (2) @(negedge clk);
    check("R6 scoreboard drained", 8'(expQ.size()), 8'h00);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule